// File: doc/BRIEF.md
# Key-Stretching Iteration Sequencer

This block runs the iteration loop that turns one password-based key derivation output block into its final 160-bit value. The host supplies the first pseudorandom-function block and the number of iterations wanted. The block then repeats a two-step keyed hash, an inner pass followed by an outer pass, through an external hash unit. After each outer pass it folds the new result into a running XOR. It also keeps the new result as the block that feeds the next iteration.

A 32-bit counter stops the loop when the requested count is reached. The running XOR is then copied into a five-word output register, and `result_ready` is raised. While `out_en` is high, that register moves one 32-bit word per clock onto `out_word`. The external hash unit reads `cur_blk` and `hash_sel` when `hash_go` pulses, and it answers with `hash_rdy` and `hash_res`.

Top module: `pbk_f_engine`

## Requirements
- R1: While reset is held and after it is released, `result_ready`, `hash_go` and `out_word` are 0 and `cur_blk` is all zeros.
- R2: When `start` is sampled high in the idle or finished state, `cur_blk` and the running XOR both take `first_blk`, the iteration counter is set to 1, and `iter_count` is captured. These values are visible from the following cycle.
- R3: Each iteration makes exactly two hash requests. `hash_go` pulses for one cycle with `hash_sel`=0 (inner step), and after the matching `hash_rdy` it pulses again with `hash_sel`=1 (outer step). No new request is made before the pending one has been answered.
- R4: On the `hash_rdy` that answers an outer step, `cur_blk` becomes `hash_res` and the running XOR becomes its old value XOR `hash_res`. An answer to an inner step changes neither.
- R5: The loop makes exactly 2*(N-1) hash requests for a captured count N≥1, and none after that.
- R6: A captured count of 0 or 1 makes no hash request, and the result is `first_blk`.
- R7: `result_ready` rises exactly two clock edges after the edge that samples the last outer `hash_rdy`. For a count of 0 or 1, it rises two edges after the edge that samples `start`.
- R8: Once `result_ready` is high, `out_word` shows bits 159:128 of the result. Each edge that samples `out_en`=1 moves the next lower 32 bits onto it. After five words it shows 0.
- R9: `hash_rdy` has no effect outside the two waiting states. In the finished state it changes neither `result_ready`, `cur_blk` nor the output words.
- R10: `start` is ignored while a computation is running, and so are changes on `first_blk` and `iter_count` after they have been captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a computation (one-cycle pulse) |
| first_blk | input | 160 | First pseudorandom-function block from the host |
| iter_count | input | 32 | Requested iteration count |
| hash_go | output | 1 | One-cycle request to the hash unit |
| hash_sel | output | 1 | Step select: 0 inner, 1 outer |
| cur_blk | output | 160 | Current block feeding the next inner step |
| hash_rdy | input | 1 | Hash unit finished, `hash_res` valid |
| hash_res | input | 160 | Hash unit result |
| out_en | input | 1 | Advance the output register by one word |
| out_word | output | 32 | Current output word |
| result_ready | output | 1 | Result loaded and available |

## Verification
Most counter faults show at the ports within one iteration. An off-by-one or a stuck counter adds or removes a pair of `hash_go` pulses, and an inverted step select shows on the first request. A fault in the current-block register shows on `cur_blk` in the cycle after the next outer answer. Corruption of the running XOR stays hidden until completion, so the five output words are compared against an independent fold of every outer result. The edge-exact rise of `result_ready` catches a skipped or extra control state.

// File: rtl/pbk_pkg.sv
package pbk_pkg;
  localparam int unsigned DIGEST_W = 160;
  localparam int unsigned BUS_W    = 32;
  localparam int unsigned ITER_W   = 32;

  typedef enum logic [3:0] {
    ST_IDLE     = 4'd0,
    ST_CHECK    = 4'd1,
    ST_IN_GO    = 4'd2,
    ST_IN_WAIT  = 4'd3,
    ST_OUT_GO   = 4'd4,
    ST_OUT_WAIT = 4'd5,
    ST_LOAD     = 4'd6,
    ST_DONE     = 4'd7
  } pbk_state_e;
endpackage

// File: rtl/pbk_ctrl.sv
module pbk_ctrl
  import pbk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic hash_rdy,
  input  logic iter_done,
  output logic hash_go,
  output logic hash_sel,
  output logic init_stb,
  output logic acc_stb,
  output logic cnt_inc,
  output logic sr_load,
  output logic result_ready
);
  pbk_state_e state_q, state_d;
  logic       accepting;

  assign accepting = (state_q == ST_IDLE) || (state_q == ST_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: if (start) state_d = ST_CHECK;
      ST_CHECK:         state_d = iter_done ? ST_LOAD : ST_IN_GO;
      ST_IN_GO:         state_d = ST_IN_WAIT;
      ST_IN_WAIT:       if (hash_rdy) state_d = ST_OUT_GO;
      ST_OUT_GO:        state_d = ST_OUT_WAIT;
      ST_OUT_WAIT:      if (hash_rdy) state_d = ST_CHECK;
      ST_LOAD:          state_d = ST_DONE;
      default:          state_d = ST_IDLE;
    endcase
  end

  assign init_stb     = accepting && start;
  assign hash_go      = (state_q == ST_IN_GO) || (state_q == ST_OUT_GO);
  assign hash_sel     = (state_q == ST_OUT_GO) || (state_q == ST_OUT_WAIT);
  assign acc_stb      = (state_q == ST_OUT_WAIT) && hash_rdy;
  assign cnt_inc      = acc_stb;
  assign sr_load      = (state_q == ST_LOAD);
  assign result_ready = (state_q == ST_DONE);

  // R3: a request lasts a single cycle
  a_r3_go_single: assert property (@(posedge clk) disable iff (!rst_n)
    hash_go |=> !hash_go);
  // R3: an outer request is always followed by waiting on the outer step
  a_r3_outer_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (hash_go && hash_sel) |=> (hash_sel && !hash_go));
  // R7: loading the output register makes the result ready next cycle
  a_r7_load_then_ready: assert property (@(posedge clk) disable iff (!rst_n)
    sr_load |=> result_ready);
  // R10: a start pulse during a running computation does not restart it
  a_r10_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!accepting && start && hash_go) |=> !hash_go);
  // R9: nothing folds while the result is on display
  a_r9_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    result_ready |-> (!acc_stb && !hash_go));
endmodule

// File: rtl/pbk_accum.sv
module pbk_accum #(
  parameter int unsigned DIGEST_W = pbk_pkg::DIGEST_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                init_stb,
  input  logic [DIGEST_W-1:0] first_blk,
  input  logic                acc_stb,
  input  logic [DIGEST_W-1:0] hash_res,
  output logic [DIGEST_W-1:0] cur_blk,
  output logic [DIGEST_W-1:0] acc_val
);
  function automatic logic [DIGEST_W-1:0] chain_fold(
    input logic [DIGEST_W-1:0] running, input logic [DIGEST_W-1:0] fresh);
    return running ^ fresh;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_blk <= '0;
      acc_val <= '0;
    end else if (init_stb) begin
      cur_blk <= first_blk;
      acc_val <= first_blk;
    end else if (acc_stb) begin
      cur_blk <= hash_res;
      acc_val <= chain_fold(acc_val, hash_res);
    end
  end

  // R2: after a start both registers carry the same first block
  a_r2_init_equal: assert property (@(posedge clk) disable iff (!rst_n)
    init_stb |=> (acc_val == cur_blk));
  // R4: the current block follows the outer result
  a_r4_cur_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && !init_stb) |=> (cur_blk == $past(hash_res)));
  // R4: without a strobe the running XOR holds
  a_r4_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_stb && !init_stb) |=> $stable(acc_val));
endmodule

// File: rtl/pbk_iter_cnt.sv
module pbk_iter_cnt #(
  parameter int unsigned ITER_W = pbk_pkg::ITER_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_stb,
  input  logic              cnt_inc,
  input  logic [ITER_W-1:0] iter_count,
  output logic              iter_done
);
  localparam logic [ITER_W-1:0] ONE = ITER_W'(1);

  logic [ITER_W-1:0] cnt_q;
  logic [ITER_W-1:0] target_q;

  function automatic logic reached(input logic [ITER_W-1:0] cnt,
                                   input logic [ITER_W-1:0] tgt);
    return cnt >= tgt;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      target_q <= '0;
    end else if (init_stb) begin
      cnt_q    <= ONE;
      target_q <= iter_count;
    end else if (cnt_inc) begin
      cnt_q    <= cnt_q + ONE;
    end
  end

  assign iter_done = reached(cnt_q, target_q);

  // R2: a start sets the count to one
  a_r2_count_one: assert property (@(posedge clk) disable iff (!rst_n)
    init_stb |=> (cnt_q == ONE));
  // R5: no iteration is counted once the target is reached
  a_r5_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_inc |-> !iter_done);
  // R10: the captured target does not move during a run
  a_r10_target_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !init_stb |=> $stable(target_q));
endmodule

// File: rtl/pbk_out_sreg.sv
module pbk_out_sreg #(
  parameter int unsigned DIGEST_W = pbk_pkg::DIGEST_W,
  parameter int unsigned BUS_W    = pbk_pkg::BUS_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sr_load,
  input  logic [DIGEST_W-1:0] load_data,
  input  logic                out_en,
  output logic [BUS_W-1:0]    out_word
);
  logic [DIGEST_W-1:0] sreg_q;

  function automatic logic [DIGEST_W-1:0] advance(input logic [DIGEST_W-1:0] v);
    return {v[DIGEST_W-BUS_W-1:0], {BUS_W{1'b0}}};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       sreg_q <= '0;
    else if (sr_load) sreg_q <= load_data;
    else if (out_en)  sreg_q <= advance(sreg_q);
  end

  assign out_word = sreg_q[DIGEST_W-1 -: BUS_W];

  // R8: a load presents the most significant word first
  a_r8_first_word: assert property (@(posedge clk) disable iff (!rst_n)
    sr_load |=> (out_word == $past(load_data[DIGEST_W-1 -: BUS_W])));
  // R8: the word holds unless loaded or advanced
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sr_load && !out_en) |=> $stable(out_word));
endmodule

// File: rtl/pbk_f_engine.sv
module pbk_f_engine
  import pbk_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [DIGEST_W-1:0] first_blk,
  input  logic [ITER_W-1:0]   iter_count,
  output logic                hash_go,
  output logic                hash_sel,
  output logic [DIGEST_W-1:0] cur_blk,
  input  logic                hash_rdy,
  input  logic [DIGEST_W-1:0] hash_res,
  input  logic                out_en,
  output logic [BUS_W-1:0]    out_word,
  output logic                result_ready
);
  logic                init_stb;
  logic                acc_stb;
  logic                cnt_inc;
  logic                sr_load;
  logic                iter_done;
  logic [DIGEST_W-1:0] acc_val;

  pbk_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .hash_rdy(hash_rdy),
    .iter_done(iter_done), .hash_go(hash_go), .hash_sel(hash_sel),
    .init_stb(init_stb), .acc_stb(acc_stb), .cnt_inc(cnt_inc),
    .sr_load(sr_load), .result_ready(result_ready)
  );

  pbk_accum #(.DIGEST_W(DIGEST_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .init_stb(init_stb), .first_blk(first_blk),
    .acc_stb(acc_stb), .hash_res(hash_res), .cur_blk(cur_blk),
    .acc_val(acc_val)
  );

  pbk_iter_cnt #(.ITER_W(ITER_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .init_stb(init_stb), .cnt_inc(cnt_inc),
    .iter_count(iter_count), .iter_done(iter_done)
  );

  pbk_out_sreg #(.DIGEST_W(DIGEST_W), .BUS_W(BUS_W)) u_sreg (
    .clk(clk), .rst_n(rst_n), .sr_load(sr_load), .load_data(acc_val),
    .out_en(out_en), .out_word(out_word)
  );

  // R1: no request and no result straight after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!hash_go && !result_ready));
endmodule

// File: tb/pbk_f_engine_tb_top.sv
`timescale 1ns/1ps
module pbk_f_engine_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [159:0] first_blk = '0;
  logic [31:0]  iter_count = '0;
  logic         hash_go, hash_sel, result_ready;
  logic [159:0] cur_blk;
  logic         hash_rdy = 1'b0;
  logic [159:0] hash_res = '0;
  logic         out_en = 1'b0;
  logic [31:0]  out_word;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int go_cnt = 0, outer_idx = 0, done_cyc = 0;
  logic [159:0] exp_acc, exp_cur;
  bit finished = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pbk_f_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .first_blk(first_blk),
    .iter_count(iter_count), .hash_go(hash_go), .hash_sel(hash_sel),
    .cur_blk(cur_blk), .hash_rdy(hash_rdy), .hash_res(hash_res),
    .out_en(out_en), .out_word(out_word), .result_ready(result_ready)
  );

  task automatic check(input bit ok, input string req,
                       input logic [159:0] act, input logic [159:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [159:0] bhash(input int k);
    logic [159:0] v;
    for (int i = 0; i < 5; i++)
      v[i*32 +: 32] = (32'(k) * 32'h9E3779B9) ^ (32'(i) * 32'h01010101) ^ 32'h5A5A0000;
    return v;
  endfunction

  // Behavioural hash unit and per-request model
  initial begin
    @(posedge clk); #1;
    forever begin
      if (hash_go) begin
        bit sel;
        int lat;
        sel = hash_sel;
        go_cnt++;
        check(sel == ((go_cnt % 2) == 0), "R3 step select", 160'(sel), 160'((go_cnt % 2) == 0));
        if (!sel) check(cur_blk == exp_cur, "R4 block fed to inner step", cur_blk, exp_cur);
        if (sel) outer_idx++;
        lat = 1 + (go_cnt % 3);
        repeat (lat) @(posedge clk);
        #1;
        hash_res = sel ? bhash(outer_idx) : ~bhash(outer_idx + 1000);
        hash_rdy = 1'b1;
        @(posedge clk);
        #1;
        hash_rdy = 1'b0;
        if (sel) begin
          exp_acc  = exp_acc ^ hash_res;
          exp_cur  = hash_res;
          done_cyc = cyc;
          check(cur_blk == hash_res, "R4 current block after outer", cur_blk, hash_res);
        end else begin
          check(cur_blk == exp_cur, "R4 inner answer not folded", cur_blk, exp_cur);
        end
      end else begin
        @(posedge clk); #1;
      end
    end
  end

  task automatic run(input logic [159:0] fb, input int c, input bit poke, input bit spur);
    int eff, guard;
    eff = (c < 1) ? 1 : c;
    first_blk = fb; iter_count = 32'(c);
    exp_acc = fb; exp_cur = fb; go_cnt = 0;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    done_cyc = cyc;
    check(cur_blk == fb, "R2 current block loaded", cur_blk, fb);
    if (poke) begin
      first_blk = ~fb; iter_count = 32'd1;
      repeat (3) @(posedge clk);
      #1 start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
    end
    guard = 0;
    while (!result_ready && guard < 2000) begin
      @(posedge clk); #1; guard++;
    end
    check(cyc == done_cyc + 2, "R7 ready timing", 160'(cyc), 160'(done_cyc + 2));
    check(go_cnt == 2 * (eff - 1), (eff == 1) ? "R6 no requests" : "R5 request count",
          160'(go_cnt), 160'(2 * (eff - 1)));
    if (poke) check(go_cnt == 2 * (eff - 1), "R10 busy start ignored", 160'(go_cnt), 160'(2 * (eff - 1)));
    if (eff == 1) check(exp_acc == fb, "R6 result is first block", exp_acc, fb);
    if (spur) begin
      hash_res = '1; hash_rdy = 1'b1;
      @(posedge clk); #1;
      hash_rdy = 1'b0;
      check(result_ready == 1'b1, "R9 ready unaffected", 160'(result_ready), 160'(1));
      check(cur_blk == exp_cur, "R9 block unaffected", cur_blk, exp_cur);
    end
    for (int i = 0; i < 5; i++) begin
      check(out_word == exp_acc[159 - 32*i -: 32], "R8 output word", 160'(out_word),
            160'(exp_acc[159 - 32*i -: 32]));
      out_en = 1'b1;
      @(posedge clk); #1;
      out_en = 1'b0;
    end
    check(out_word == 32'h0, "R8 drained word", 160'(out_word), 160'(0));
    repeat (2) @(posedge clk); #1;
    check(go_cnt == 2 * (eff - 1), "R5 no request after done", 160'(go_cnt), 160'(2 * (eff - 1)));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(result_ready == 1'b0, "R1 ready low in reset", 160'(result_ready), 160'(0));
    check(hash_go == 1'b0, "R1 no request in reset", 160'(hash_go), 160'(0));
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(out_word == 32'h0, "R1 output word zero", 160'(out_word), 160'(0));
    check(cur_blk == '0, "R1 block zero", cur_blk, 160'(0));
    run({5{32'h0123_4567}} ^ 160'hABCDEF, 1, 1'b0, 1'b0);
    run(bhash(77), 0, 1'b0, 1'b0);
    run(bhash(5), 4, 1'b0, 1'b1);
    run(~bhash(9), 7, 1'b1, 1'b0);
    run(bhash(31), 20, 1'b0, 1'b1);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule